// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Timer Pair

Two 8-bit up-counters, channel 0 and channel 1, that each compare their count against two registers (A and B). Each channel has a clock-select field, a counter-clear field, an output-control field, two sticky compare-match flags and one output pin. Clock sources arrive from an outside prescaler as single-cycle enable strobes (`pre_en`). A match event is the cycle in which a counter first equals a compare value. It sets a flag, may clear the counter and drives the output pin.

Clock-select code 100 chains the two channels. When channel 0 holds the code, the pair becomes one 16-bit counter: channel 0 is the high byte and channel 1 the low byte. When only channel 1 holds it, channel 1 counts the compare-A events of channel 0. A write port and a combinational read port reach all registers. Address bit 3 picks the channel and bits 2:0 pick the register: 0 control, 1 output control, 2 status, 3 counter, 4 compare A, 5 compare B.

Top module: `tmr8_pair`

## Requirements
- R1: After reset every counter reads 0, every compare register reads 0xFF, both status registers read 0 and both `tmo` pins are 0. Control byte layout: bits 2:0 clock select, bits 4:3 clear select. Output-control byte layout: bits 1:0 action on A, bits 3:2 action on B. Status byte: bit 0 flag A, bit 1 flag B.
- R2: Clock-select codes 001, 010 and 011 advance the counter by one on each strobe of `pre_en[0]`, `pre_en[1]` and `pre_en[2]` respectively. Code 000 (and the unused codes 101 to 111) stops the counter.
- R3: When a counter first becomes equal to a compare register, the matching flag is set on the next edge. The flag then stays set until the clear protocol of R4 removes it. If a match and a clearing write land in the same cycle, the flag stays set.
- R4: A flag is cleared only by writing 0 to its status bit after a status read that returned that bit as 1. A write of 0 without such a read leaves the flag set. Writing 1 has no effect.
- R5: An output-control action of 00 leaves the pin unchanged, 01 drives it low, 10 drives it high and 11 toggles it. When A and B match in the same cycle, B's action is applied.
- R6: Clear-select 00 never clears, 01 clears on a compare-A match, 10 clears on a compare-B match, and 11 clears on a rising edge of that channel's `ext_clr` bit. The clear takes effect one edge after the event.
- R7: With code 100 in channel 0, the two channels form one 16-bit counter {ch0, ch1}. The low byte runs from channel 1's selected strobe. The high byte advances on the edge where the low byte wraps from 0xFF to 0x00.
- R8: In 16-bit mode, channel 0's flags are set by 16-bit matches against {cmp ch0, cmp ch1}. Channel 1's flags are set by low-byte matches alone.
- R9: In 16-bit mode, channel 0's clear select clears the whole 16-bit counter. Channel 1's clear select is ignored, so the low byte is never cleared on its own.
- R10: In 16-bit mode, `tmo[0]` follows 16-bit match events under channel 0's output control. `tmo[1]` follows low-byte match events under channel 1's output control.
- R11: With code 100 in channel 1 only, channel 1 advances once per compare-A event of channel 0. Each channel keeps its own flags, output and clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_en | input | 3 | Prescaler enable strobes |
| ext_clr | input | 2 | External clear inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address {channel, register} |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read strobe, used to arm the flag clear |
| rd_addr | input | 4 | Read address {channel, register} |
| rd_data | output | W | Read data (combinational) |
| tmo | output | 2 | Timer output pins |

## Verification
Every cycle, assertions check four things. A set flag stays set unless a status write arrives, and a match event always sets its flag. A pin holds its level when its channel has no match event. The cascade stepping must hold: the high byte advances on a low-byte wrap, channel 1 advances on each channel 0 compare-A event, and the low byte stays put in 16-bit mode without a strobe. Only the bench scenarios can show the rest. These are the output action encodings and the B-over-A priority, the read-then-write flag protocol, and the external-clear edge. They also include the split flags and pins of the 16-bit mode and the full event counts in the chained mode.

// File: rtl/tmr8_pair.sv
module tmr8_pair #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   pre_en,
  input  logic [1:0]   ext_clr,
  input  logic         wr_en,
  input  logic [3:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic [3:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic [1:0]   tmo
);

  localparam int A_CTRL = 0;
  localparam int A_OCTL = 1;
  localparam int A_STAT = 2;
  localparam int A_CNT  = 3;
  localparam int A_CMPA = 4;
  localparam int A_CMPB = 5;
  localparam logic [2:0] CK_CHAIN = 3'b100;

  logic [W-1:0] cnt [2];
  logic [W-1:0] cmpa [2];
  logic [W-1:0] cmpb [2];
  logic [2:0]   cks [2];
  logic [1:0]   cclr [2];
  logic [1:0]   osa [2];
  logic [1:0]   osb [2];
  logic [1:0]   act [2];
  logic [5:0]   wsel [2];
  logic [1:0]   cmfa, cmfb, arma, armb, eqa_q, eqb_q, ext_q, tmo_q, tmo_d;
  logic [1:0]   eqa, eqb, eva, evb, tick, inc, clr_raw, clr_eff, rstat, ext_rise;
  logic         wide, evcnt;

  assign wide  = (cks[0] == CK_CHAIN);
  assign evcnt = !wide && (cks[1] == CK_CHAIN);

  assign eqa[0] = wide ? ({cnt[0], cnt[1]} == {cmpa[0], cmpa[1]}) : (cnt[0] == cmpa[0]);
  assign eqb[0] = wide ? ({cnt[0], cnt[1]} == {cmpb[0], cmpb[1]}) : (cnt[0] == cmpb[0]);
  assign eqa[1] = (cnt[1] == cmpa[1]);
  assign eqb[1] = (cnt[1] == cmpb[1]);
  assign eva = eqa & ~eqa_q;
  assign evb = eqb & ~eqb_q;
  assign ext_rise = ext_clr & ~ext_q;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      tick[i] = (cks[i] == 3'd1 && pre_en[0]) ||
                (cks[i] == 3'd2 && pre_en[1]) ||
                (cks[i] == 3'd3 && pre_en[2]);
      case (cclr[i])
        2'b01:   clr_raw[i] = eva[i];
        2'b10:   clr_raw[i] = evb[i];
        2'b11:   clr_raw[i] = ext_rise[i];
        default: clr_raw[i] = 1'b0;
      endcase
      wsel[i]  = (wr_en && wr_addr[3] == i[0]) ? (6'b1 << wr_addr[2:0]) : 6'b0;
      rstat[i] = rd_en && rd_addr == {i[0], 3'(A_STAT)};
      act[i]   = evb[i] ? osb[i] : (eva[i] ? osa[i] : 2'b00);
      case (act[i])
        2'b01:   tmo_d[i] = 1'b0;
        2'b10:   tmo_d[i] = 1'b1;
        2'b11:   tmo_d[i] = ~tmo_q[i];
        default: tmo_d[i] = tmo_q[i];
      endcase
    end
  end

  assign inc[1] = evcnt ? eva[0] : tick[1];
  assign inc[0] = wide ? (inc[1] && cnt[1] == '1) : tick[0];
  assign clr_eff[0] = clr_raw[0];
  assign clr_eff[1] = wide ? clr_raw[0] : clr_raw[1];
  assign tmo = tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        cnt[i]  <= '0;
        cmpa[i] <= '1;
        cmpb[i] <= '1;
        cks[i]  <= '0;
        cclr[i] <= '0;
        osa[i]  <= '0;
        osb[i]  <= '0;
      end
      cmfa  <= '0;
      cmfb  <= '0;
      arma  <= '0;
      armb  <= '0;
      eqa_q <= '0;
      eqb_q <= '0;
      ext_q <= '0;
      tmo_q <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (wsel[i][A_CNT])       cnt[i] <= wr_data;
        else if (clr_eff[i])      cnt[i] <= '0;
        else if (inc[i])          cnt[i] <= cnt[i] + 1'b1;
        if (wsel[i][A_CMPA]) cmpa[i] <= wr_data;
        if (wsel[i][A_CMPB]) cmpb[i] <= wr_data;
        if (wsel[i][A_CTRL]) begin
          cks[i]  <= wr_data[2:0];
          cclr[i] <= wr_data[4:3];
        end
        if (wsel[i][A_OCTL]) begin
          osa[i] <= wr_data[1:0];
          osb[i] <= wr_data[3:2];
        end
        if (eva[i])                                      cmfa[i] <= 1'b1;
        else if (wsel[i][A_STAT] && !wr_data[0] && arma[i]) cmfa[i] <= 1'b0;
        if (evb[i])                                      cmfb[i] <= 1'b1;
        else if (wsel[i][A_STAT] && !wr_data[1] && armb[i]) cmfb[i] <= 1'b0;
        if (wsel[i][A_STAT])            arma[i] <= 1'b0;
        else if (rstat[i] && cmfa[i])   arma[i] <= 1'b1;
        if (wsel[i][A_STAT])            armb[i] <= 1'b0;
        else if (rstat[i] && cmfb[i])   armb[i] <= 1'b1;
      end
      eqa_q <= eqa;
      eqb_q <= eqb;
      ext_q <= ext_clr;
      tmo_q <= tmo_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr[2:0])
      3'(A_CTRL): rd_data[4:0] = {cclr[rd_addr[3]], cks[rd_addr[3]]};
      3'(A_OCTL): rd_data[3:0] = {osb[rd_addr[3]], osa[rd_addr[3]]};
      3'(A_STAT): rd_data[1:0] = {cmfb[rd_addr[3]], cmfa[rd_addr[3]]};
      3'(A_CNT):  rd_data = cnt[rd_addr[3]];
      3'(A_CMPA): rd_data = cmpa[rd_addr[3]];
      3'(A_CMPB): rd_data = cmpb[rd_addr[3]];
      default:    rd_data = '0;
    endcase
  end

  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmfa[0] && !wsel[0][A_STAT] |=> cmfa[0]);

  p_event_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eva[1] |=> cmfa[1]);

  p_tmo_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !eva[0] && !evb[0] |=> $stable(tmo[0]));

  p_wide_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wide && tick[1] && cnt[1] == '1 && !clr_eff[0] && !wr_en |=> cnt[0] == $past(cnt[0]) + 1'b1);

  p_low_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wide && !wr_en && !clr_eff[0] && !tick[1] |=> $stable(cnt[1]));

  p_cmcount_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evcnt && eva[0] && !clr_eff[1] && !wr_en |=> cnt[1] == $past(cnt[1]) + 1'b1);

endmodule

// File: tb/tmr8_pair_tb.sv
module tmr8_pair_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] pre_en = '0;
  logic [1:0] ext_clr = '0;
  logic       wr_en = 0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] tmo;
  int checks = 0;
  int errors = 0;

  tmr8_pair #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .ext_clr(ext_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tmo(tmo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {start, cmpA, cmpB, actA, actB, strobes, exp tmo0, exp status}
  localparam logic [34:0] TBL [8] = '{
    {8'h10, 8'h12, 8'h20, 2'b10, 2'b00, 4'd2, 1'b1, 2'b01},
    {8'h10, 8'h12, 8'h14, 2'b10, 2'b01, 4'd4, 1'b0, 2'b11},
    {8'h10, 8'h11, 8'h20, 2'b11, 2'b00, 4'd1, 1'b1, 2'b01},
    {8'h10, 8'h11, 8'h11, 2'b10, 2'b01, 4'd1, 1'b0, 2'b11},
    {8'h10, 8'h11, 8'h11, 2'b01, 2'b10, 4'd1, 1'b1, 2'b11},
    {8'h10, 8'h11, 8'h20, 2'b00, 2'b00, 4'd1, 1'b0, 2'b01},
    {8'h10, 8'h30, 8'h40, 2'b10, 2'b10, 4'd3, 1'b0, 2'b00},
    {8'hFE, 8'h00, 8'h80, 2'b10, 2'b00, 4'd2, 1'b1, 2'b01}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk) begin wr_en = 1; wr_addr = a; wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk) begin rd_addr = a; rd_en = 1; end
    #1 d = rd_data;
    @(negedge clk) rd_en = 0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) pre_en[idx] = 1'b1;
      @(negedge clk) pre_en = '0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] d;
    do_reset();

    // R1 reset state
    chk("R1 tmo", 16'(tmo), 16'h0);
    rd(4'h3, d); chk("R1 cnt0", 16'(d), 16'h00);
    rd(4'hB, d); chk("R1 cnt1", 16'(d), 16'h00);
    rd(4'h4, d); chk("R1 cmpa0", 16'(d), 16'hFF);
    rd(4'hD, d); chk("R1 cmpb1", 16'(d), 16'hFF);
    rd(4'h2, d); chk("R1 stat0", 16'(d), 16'h00);

    // R5 R3 R2 table of output-control scenarios on channel 0
    for (int v = 0; v < 8; v++) begin
      logic [34:0] e;
      e = TBL[v];
      do_reset();
      wr(4'h0, 8'h01);
      wr(4'h3, e[34:27]);
      wr(4'h4, e[26:19]);
      wr(4'h5, e[18:11]);
      wr(4'h1, {4'h0, e[8:7], e[10:9]});
      pulse(0, int'(e[6:3]));
      chk($sformatf("R5 vec%0d tmo0", v), 16'(tmo[0]), 16'(e[2]));
      rd(4'h2, d);
      chk($sformatf("R3 vec%0d stat0", v), 16'(d), 16'(e[1:0]));
    end

    // R2 clock select and stop
    do_reset();
    wr(4'h8, 8'h02);
    pulse(1, 3);
    pulse(0, 2);
    rd(4'hB, d); chk("R2 sel010", 16'(d), 16'h03);
    wr(4'h8, 8'h00);
    pulse(1, 2);
    rd(4'hB, d); chk("R2 stopped", 16'(d), 16'h03);

    // R6 external clear on rising edge
    do_reset();
    wr(4'h0, 8'h19);
    wr(4'h3, 8'h40);
    @(negedge clk) ext_clr[0] = 1;
    @(negedge clk);
    @(negedge clk) ext_clr[0] = 0;
    rd(4'h3, d); chk("R6 ext clear", 16'(d), 16'h00);

    // R7 R8 R9 R10 16-bit mode
    do_reset();
    wr(4'h8, 8'h09);
    wr(4'h0, 8'h0C);
    wr(4'h4, 8'h01);
    wr(4'hC, 8'h02);
    wr(4'h1, 8'h02);
    wr(4'h9, 8'h03);
    pulse(0, 2);
    rd(4'hB, d); chk("R9 low not cleared", 16'(d), 16'h02);
    rd(4'hA, d); chk("R8 low flag", 16'(d[0]), 16'h1);
    rd(4'h2, d); chk("R8 16b flag clear", 16'(d), 16'h00);
    chk("R10 pins", 16'(tmo), 16'h2);
    wr(4'hB, 8'hFE);
    pulse(0, 2);
    rd(4'h3, d); chk("R7 carry high", 16'(d), 16'h01);
    rd(4'hB, d); chk("R7 low wrapped", 16'(d), 16'h00);
    pulse(0, 2);
    rd(4'h3, d); chk("R9 clear high", 16'(d), 16'h00);
    rd(4'hB, d); chk("R9 clear low", 16'(d), 16'h00);
    rd(4'h2, d); chk("R8 16b flag", 16'(d[0]), 16'h1);
    chk("R10 pins after", 16'(tmo), 16'h1);

    // R11 compare-match count, then R4 flag clear protocol
    do_reset();
    wr(4'h0, 8'h09);
    wr(4'h4, 8'h03);
    wr(4'h8, 8'h04);
    pulse(0, 8);
    rd(4'hB, d); chk("R11 events counted", 16'(d), 16'h02);
    rd(4'h3, d); chk("R11 ch0 own clear", 16'(d), 16'h02);
    rd(4'hA, d); chk("R11 ch1 flags", 16'(d), 16'h00);
    wr(4'h2, 8'h00);
    rd(4'h2, d); chk("R4 no read no clear", 16'(d[0]), 16'h1);
    wr(4'h2, 8'h00);
    rd(4'h2, d); chk("R4 cleared", 16'(d[0]), 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule